// File: doc/BRIEF.md
# Endpoint 0 Handshake Controller

This block holds the control state of the default control endpoint of a low-speed USB function and decides, token by token, how the function answers the host. Software programs it through a small register port. One register holds the data-toggle select, a forced-stall bit, transmit and receive enables, and a transmit packet size. A second register holds the transmit-done and end-of-packet status flags, their write-one-to-clear strobes, and an interrupt enable.

On the protocol side, a token decoder presents each decoded token (IN, OUT or SETUP) for one cycle. One clock later the block returns a registered response: DATA with the PID selected by the toggle bit, STALL, NAK or ACK. The packet engine reports the end of each IN data transmission, and the line monitor reports each end of packet. These events set the status flags. An end-of-packet flag raises the interrupt line only when the interrupt is enabled. The data toggle belongs to software alone. Hardware changes only the stall bit, which it clears when a SETUP token arrives.

Top module: `ep0_hs_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irq` is 0 and `rsp_valid` is 0.
- R2: The control register (`reg_sel`=0) reads back what was written. Its layout is bit 7 toggle, bit 6 stall, bit 5 transmit enable, bit 4 receive enable, bits 3:0 transmit size.
- R3: An IN or OUT token while the stall bit is 1 is answered with STALL (`rsp_code`=2'b10).
- R4: A SETUP token is answered with ACK (2'b00) and clears the stall bit. This holds even when software writes stall=1 in the same cycle.
- R5: If not stalled, an IN token is answered with NAK (2'b01) when transmit enable is 0 or the transmit-done flag is 1.
- R6: If not stalled, with transmit enable 1 and transmit-done 0, an IN token is answered with DATA (2'b11). `rsp_data1` then equals the toggle bit. Hardware never changes the toggle bit.
- R7: If not stalled, an OUT token is answered with NAK when receive enable is 0, and with ACK otherwise.
- R8: A `tx_done` pulse sets the transmit-done flag (status bit 7). Writing the status register with bit 4 set clears the flag. Writing bit 4 as 0 leaves it unchanged.
- R9: An `eop_evt` pulse sets the end-of-packet flag (status bit 6). Writing the status register with bit 3 set clears the flag. Writing bit 3 as 0 leaves it unchanged.
- R10: `irq` is 1 exactly when the interrupt enable (status bit 5, read/write) and the end-of-packet flag are both 1.
- R11: When a flag is set by hardware and cleared by software in the same cycle, the flag ends up set.
- R12: Status bits 4, 3 and 2:0 always read as 0.
- R13: A token (`tok_kind` 01=IN, 10=OUT, 11=SETUP) with `tok_valid` produces a response with `rsp_valid`=1 exactly one cycle later. No token, or code 00, produces `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | Token type: 01 IN, 10 OUT, 11 SETUP |
| tx_done | input | 1 | IN data transmission finished |
| eop_evt | input | 1 | End of packet detected |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 ACK, 01 NAK, 10 STALL, 11 DATA |
| rsp_data1 | output | 1 | DATA1 PID selected (DATA responses only) |
| irq | output | 1 | End-of-packet interrupt |

## Verification
The hardest situations to reach are coincidences of two sources in one cycle. One is a SETUP token arriving while software writes the stall bit. The other is a hardware flag set landing on the same edge as its software clear. The bench drives both by lining up the register strobe with the token or event pulse on a single clock. The response decision is swept over every combination of the four control bits, both states of the transmit-done flag, and all three token kinds. Each expected code comes from the priority rules.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;
    localparam int SIZE_W = 4;
    localparam int CTRL_W = SIZE_W + 4;

    // status register bit positions
    localparam int ST_TXD    = 7;
    localparam int ST_EOP    = 6;
    localparam int ST_IE     = 5;
    localparam int ST_TXCLR  = 4;
    localparam int ST_EOPCLR = 3;

    typedef enum logic [1:0] {
        TOK_NONE  = 2'b00,
        TOK_IN    = 2'b01,
        TOK_OUT   = 2'b10,
        TOK_SETUP = 2'b11
    } tok_e;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'b00,
        RSP_NAK   = 2'b01,
        RSP_STALL = 2'b10,
        RSP_DATA  = 2'b11
    } rsp_e;

    typedef struct packed {
        logic              toggle;
        logic              stall;
        logic              tx_en;
        logic              rx_en;
        logic [SIZE_W-1:0] size;
    } ctrl_t;

    typedef struct packed {
        logic txd;
        logic eop;
        logic ie;
    } flags_t;

    typedef struct packed {
        logic valid;
        rsp_e code;
        logic data1;
    } rsp_t;
endpackage

// File: rtl/ep0_ctrl_reg.sv
module ep0_ctrl_reg
    import ep0_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              setup_seen,
    output ctrl_t             ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = ctrl_t'(wdata);
        end
        // hardware stall release overrides a concurrent software write
        if (setup_seen) begin
            ctrl_d.stall = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/ep0_status_flags.sv
module ep0_status_flags
    import ep0_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              tx_done,
    input  logic              eop_evt,
    output flags_t            flags_q,
    output logic              irq
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (wr_en) begin
            flags_d.ie = wdata[ST_IE];
            if (wdata[ST_TXCLR]) begin
                flags_d.txd = 1'b0;
            end
            if (wdata[ST_EOPCLR]) begin
                flags_d.eop = 1'b0;
            end
        end
        // events applied last: a set beats a same-cycle clear
        if (tx_done) begin
            flags_d.txd = 1'b1;
        end
        if (eop_evt) begin
            flags_d.eop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign irq = flags_q.ie & flags_q.eop;
endmodule

// File: rtl/ep0_hs_decide.sv
module ep0_hs_decide
    import ep0_hs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tok_valid,
    input  tok_e  tok_kind,
    input  ctrl_t ctrl,
    input  logic  txd_flag,
    output rsp_t  rsp_q
);
    rsp_t rsp_d;

    always_comb begin
        rsp_d.valid = 1'b0;
        rsp_d.code  = RSP_ACK;
        rsp_d.data1 = 1'b0;
        if (tok_valid) begin
            unique case (tok_kind)
                TOK_SETUP: begin
                    rsp_d.valid = 1'b1;
                    rsp_d.code  = RSP_ACK;
                end
                TOK_IN: begin
                    rsp_d.valid = 1'b1;
                    if (ctrl.stall) begin
                        rsp_d.code = RSP_STALL;
                    end else if (!ctrl.tx_en || txd_flag) begin
                        rsp_d.code = RSP_NAK;
                    end else begin
                        rsp_d.code  = RSP_DATA;
                        rsp_d.data1 = ctrl.toggle;
                    end
                end
                TOK_OUT: begin
                    rsp_d.valid = 1'b1;
                    if (ctrl.stall) begin
                        rsp_d.code = RSP_STALL;
                    end else if (!ctrl.rx_en) begin
                        rsp_d.code = RSP_NAK;
                    end else begin
                        rsp_d.code = RSP_ACK;
                    end
                end
                default: begin
                    rsp_d.valid = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end
endmodule

// File: rtl/ep0_hs_ctrl.sv
module ep0_hs_ctrl
    import ep0_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic              tx_done,
    input  logic              eop_evt,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              rsp_data1,
    output logic              irq
);
    ctrl_t  ctrl_q;
    flags_t flags_q;
    rsp_t   rsp_q;
    logic   setup_seen;
    logic   ctrl_wr;
    logic   stat_wr;

    assign ctrl_wr    = reg_wr_en & ~reg_sel;
    assign stat_wr    = reg_wr_en &  reg_sel;
    assign setup_seen = tok_valid & (tok_e'(tok_kind) == TOK_SETUP);

    ep0_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_wr),
        .wdata      (reg_wdata),
        .setup_seen (setup_seen),
        .ctrl_q     (ctrl_q)
    );

    ep0_status_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stat_wr),
        .wdata   (reg_wdata),
        .tx_done (tx_done),
        .eop_evt (eop_evt),
        .flags_q (flags_q),
        .irq     (irq)
    );

    ep0_hs_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_kind  (tok_e'(tok_kind)),
        .ctrl      (ctrl_q),
        .txd_flag  (flags_q.txd),
        .rsp_q     (rsp_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[ST_TXD] = flags_q.txd;
            reg_rdata[ST_EOP] = flags_q.eop;
            reg_rdata[ST_IE]  = flags_q.ie;
        end else begin
            reg_rdata = ctrl_q;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;
    assign rsp_data1 = rsp_q.data1;
endmodule

// File: rtl/ep0_hs_ctrl_chk.sv
module ep0_hs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic       reg_sel,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       tx_done,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic       irq,
    input logic       toggle,
    input logic       stall,
    input logic       tx_en,
    input logic       txd_flag,
    input logic       eop_ie
);
    // R13
    rsp_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind != 2'b00) |=> rsp_valid);

    // R13
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_valid || tok_kind == 2'b00) |=> !rsp_valid);

    // R3
    stall_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && (tok_kind == 2'b01 || tok_kind == 2'b10) && stall)
        |=> (rsp_valid && rsp_code == 2'b10));

    // R4
    setup_unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'b11) |=> (!stall && rsp_code == 2'b00));

    // R5
    in_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'b01 && !stall && (!tx_en || txd_flag))
        |=> (rsp_code == 2'b01));

    // R6
    toggle_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && !reg_sel) |=> $stable(toggle));

    // R11
    txd_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> txd_flag);

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eop_ie |-> !irq);
endmodule

bind ep0_hs_ctrl ep0_hs_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .tx_done   (tx_done),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .irq       (irq),
    .toggle    (ctrl_q.toggle),
    .stall     (ctrl_q.stall),
    .tx_en     (ctrl_q.tx_en),
    .txd_flag  (flags_q.txd),
    .eop_ie    (flags_q.ie)
);

// File: tb/ep0_hs_ctrl_tb.sv
module ep0_hs_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'b00;
    logic       tx_done = 1'b0;
    logic       eop_evt = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_code;
    logic       rsp_data1;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ep0_hs_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind),
        .tx_done   (tx_done),
        .eop_evt   (eop_evt),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .rsp_data1 (rsp_data1),
        .irq       (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic token(input logic [1:0] k);
        tok_valid = 1'b1; tok_kind = k;
        @(negedge clk);
        tok_valid = 1'b0; tok_kind = 2'b00;
    endtask

    task automatic pulse_txd();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_eop();
        eop_evt = 1'b1;
        @(negedge clk);
        eop_evt = 1'b0;
    endtask

    function automatic logic [1:0] exp_code(input logic [1:0] k, input logic stl,
                                            input logic txe, input logic rxe, input logic txd);
        if (k == 2'b11) return 2'b00;
        if (stl) return 2'b10;
        if (k == 2'b01) return (!txe || txd) ? 2'b01 : 2'b11;
        return rxe ? 2'b00 : 2'b01;
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(1'b0, r); check("R1 ctrl", r, 8'h00);
        rd(1'b1, r); check("R1 status", r, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 full readback sweep of the control register
        for (int v = 0; v < 256; v++) begin
            wr(1'b0, 8'(v));
            rd(1'b0, r);
            check("R2 readback", r, v);
        end

        // R3 R5 R6 R7 R4 R13 decision sweep
        for (int c = 0; c < 16; c++) begin
            for (int t = 0; t < 2; t++) begin
                for (int k = 1; k < 4; k++) begin
                    logic [7:0] cv;
                    logic [1:0] ec;
                    string tag;
                    cv = {4'(c), 4'(k + 4 * t)};
                    wr(1'b1, 8'h10);
                    if (t == 1) pulse_txd();
                    wr(1'b0, cv);
                    token(2'(k));
                    ec = exp_code(2'(k), cv[6], cv[5], cv[4], 1'(t));
                    if (k == 3) tag = "R4";
                    else if (cv[6]) tag = "R3";
                    else if (k == 1 && ec == 2'b01) tag = "R5";
                    else if (k == 1) tag = "R6";
                    else tag = "R7";
                    check({tag, " code"}, rsp_code, ec);
                    check("R13 valid", rsp_valid, 1);
                    if (ec == 2'b11) check("R6 pid", rsp_data1, cv[7]);
                    rd(1'b0, r);
                    check({tag, " ctrl after token"}, r,
                          (k == 3) ? (cv & 8'hBF) : cv);
                    @(negedge clk);
                    check("R13 one-shot", rsp_valid, 0);
                end
            end
        end

        // R13 code 00 with tok_valid yields nothing
        token(2'b00);
        check("R13 none", rsp_valid, 0);

        // R4 SETUP coincident with software stall write
        reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hE0;
        tok_valid = 1'b1; tok_kind = 2'b11;
        @(negedge clk);
        reg_wr_en = 1'b0; tok_valid = 1'b0; tok_kind = 2'b00;
        rd(1'b0, r); check("R4 coincident", r, 8'hA0);

        // R8 transmit-done flag
        wr(1'b1, 8'h10);
        pulse_txd();
        rd(1'b1, r); check("R8 set", r[7], 1);
        wr(1'b1, 8'h08);
        rd(1'b1, r); check("R8 write0 no effect", r[7], 1);
        wr(1'b1, 8'h10);
        rd(1'b1, r); check("R8 clear", r[7], 0);

        // R9 end-of-packet flag
        pulse_eop();
        rd(1'b1, r); check("R9 set", r[6], 1);
        wr(1'b1, 8'h10);
        rd(1'b1, r); check("R9 write0 no effect", r[6], 1);
        wr(1'b1, 8'h08);
        rd(1'b1, r); check("R9 clear", r[6], 0);

        // R10 irq sweep over enable x flag
        for (int ie = 0; ie < 2; ie++) begin
            for (int f = 0; f < 2; f++) begin
                wr(1'b1, 8'h08 | (ie != 0 ? 8'h20 : 8'h00));
                if (f == 1) pulse_eop();
                rd(1'b1, r); check("R10 ie readback", r[5], ie);
                check("R10 irq", irq, ie & f);
            end
        end

        // R11 set wins over same-cycle clear
        reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h18;
        tx_done = 1'b1; eop_evt = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; tx_done = 1'b0; eop_evt = 1'b0;
        rd(1'b1, r);
        check("R11 txd", r[7], 1);
        check("R11 eop", r[6], 1);

        // R12 write-only strobes and spare bits read 0
        wr(1'b1, 8'hFF);
        rd(1'b1, r); check("R12 low bits", r[4:0], 0);
        check("R12 ie kept", r[5], 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule